// File: doc/BRIEF.md
# One-Shot OTG Timeout Timer

This block is a single memory-mapped timer register for an OTG controller. Software writes one 32-bit word. The top bit of that word decides what the write does. When the bit is set, the timer is armed with the count held in the low 27 bits. When the bit is clear, any countdown in progress is cancelled. The countdown advances only on device-clock ticks, which arrive on a tick-enable strobe from the 60 MHz device clock.

When the count runs out, the register clears itself to zero. The block then emits a one-cycle timeout pulse. The surrounding interrupt logic latches that pulse into bit 16 of its top-level interrupt source. A read always shows the word last written, or zero after an expiry, and never shows the remaining count.

Top module: `otg_oneshot_timer`

## Requirements
- R1: After reset, the read data is 0x00000000 and the timeout pulse is low.
- R2: The read data equals the full 32-bit word last written, including bits 30:27. It does not change while the countdown runs.
- R3: A selected write with bit 31 set and a count N ≥ 1 in bits 26:0 arms the timer. The timeout pulse is high in the cycle after the Nth tick-enable cycle and not before. Bits 30:27 do not affect the count.
- R4: An armed count of zero expires on the first tick-enable cycle.
- R5: A selected write with bit 31 clear cancels a running countdown. No timeout pulse follows, and the read data is the written word.
- R6: On expiry the read data becomes 0x00000000 in the same cycle that the pulse is high. The pulse lasts exactly one cycle.
- R7: A new arming write while the timer runs restarts the countdown from the new count.
- R8: Cycles without tick enable do not advance the countdown.
- R9: A write with the register select low has no effect.
- R10: When a selected write and a tick fall in the same cycle, the write takes effect and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 1 | Register select for this timer |
| regWr | input | 1 | Write strobe |
| regWrData | input | 32 | Write data word |
| regRdData | output | 32 | Read data word |
| tickEn | input | 1 | One device-clock tick per high cycle |
| timeoutPulse | output | 1 | One-cycle expiry event |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 27-bit count field and the enable at bit 31. With those values the short counts of 0 to 10 reach every corner of the countdown within a few cycles. The corners covered are expiry at zero and one, a restart mid-count, a cancel, and a write landing on a tick. Sparse tick patterns check that idle cycles leave the count alone. Set bits 30:27 in the written word check that readback keeps them while the count ignores them.

// File: rtl/otg_tmr_pkg.sv
package otg_tmr_pkg;

  typedef struct packed {
    logic loadShadow;
    logic loadCount;
    logic decCount;
    logic expire;
    logic armed;
  } ctlStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tmrState_t;

endpackage

// File: rtl/otg_tmr_ctl.sv
module otg_tmr_ctl
  import otg_tmr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regSel,
  input  logic        regWr,
  input  logic        enBit,
  input  logic        tickEn,
  input  logic        cntLastTick,
  output ctlStrobes_t strb,
  output logic        timeoutPulse
);

  tmrState_t state, stateNext;
  logic wrHit, armWr, cancelWr;

  assign wrHit    = regSel & regWr;
  assign armWr    = wrHit & enBit;
  assign cancelWr = wrHit & ~enBit;

  // A write always wins over a tick in the same cycle.
  always_comb begin
    strb            = '0;
    strb.loadShadow = wrHit;
    strb.loadCount  = armWr;
    strb.armed      = (state == ST_RUN);
    if (!wrHit && state == ST_RUN && tickEn) begin
      if (cntLastTick) strb.expire   = 1'b1;
      else             strb.decCount = 1'b1;
    end
  end

  always_comb begin
    stateNext = state;
    if (armWr)            stateNext = ST_RUN;
    else if (cancelWr)    stateNext = ST_IDLE;
    else if (strb.expire) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      timeoutPulse <= 1'b0;
    end else begin
      state        <= stateNext;
      timeoutPulse <= strb.expire;
    end
  end

  // R5: a cancelling write is never followed by a timeout
  a_r5_cancel_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cancelWr |=> !timeoutPulse);

  // R3: no timeout unless the timer was running
  a_r3_idle_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |=> !timeoutPulse);

  // R10: a write in a tick cycle suppresses expiry
  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrHit && tickEn) |=> !timeoutPulse);

endmodule

// File: rtl/otg_tmr_dp.sv
module otg_tmr_dp
  import otg_tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 27
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] regWrData,
  input  ctlStrobes_t       strb,
  output logic              cntLastTick,
  output logic [DATA_W-1:0] shadowReg
);

  logic [CNT_W-1:0] cnt;

  assign cntLastTick = (cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowReg <= '0;
    end else if (strb.loadShadow) begin
      shadowReg <= regWrData;
    end else if (strb.expire) begin
      shadowReg <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.loadCount) begin
      cnt <= regWrData[CNT_W-1:0];
    end else if (strb.decCount) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  // R7: while running, the remaining count never exceeds the loaded count
  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    strb.armed |-> (cnt <= shadowReg[CNT_W-1:0]));

  // R2: readback holds steady during countdown
  a_r2_shadow_stable: assert property (@(posedge clk) disable iff (!rstN)
    (strb.armed && !strb.loadShadow && !strb.expire) |=> $stable(shadowReg));

endmodule

// File: rtl/otg_oneshot_timer.sv
module otg_oneshot_timer
  import otg_tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 27,
  parameter int EN_BIT = 31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              tickEn,
  output logic              timeoutPulse
);

  ctlStrobes_t strb;
  logic cntLastTick;

  otg_tmr_ctl u_ctl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .enBit(regWrData[EN_BIT]), .tickEn(tickEn), .cntLastTick(cntLastTick),
    .strb(strb), .timeoutPulse(timeoutPulse)
  );

  otg_tmr_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrData(regWrData), .strb(strb),
    .cntLastTick(cntLastTick), .shadowReg(regRdData)
  );

  // R6: register reads zero while the pulse is out
  a_r6_zero_on_expire: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> (regRdData == '0));

  // R6: pulse lasts a single cycle
  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);

endmodule

// File: tb/otg_oneshot_timer_tb.sv
module otg_oneshot_timer_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regSel, regWr, tickEn;
  logic [31:0] regWrData, regRdData;
  logic        timeoutPulse;

  int checks = 0;
  int fails  = 0;
  int pulseCnt = 0;
  bit done = 0;

  otg_oneshot_timer u_dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData),
    .tickEn(tickEn), .timeoutPulse(timeoutPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) if (rstN && timeoutPulse) pulseCnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] d, input logic sel = 1'b1);
    regSel = sel; regWr = 1'b1; regWrData = d;
    @(negedge clk);
    regSel = 1'b0; regWr = 1'b0; regWrData = '0;
  endtask

  task automatic doTicks(input int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic doIdle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    chk("R1 read", regRdData, 32'h0);
    chk("R1 pulse", {31'b0, timeoutPulse}, 32'h0);
  endtask

  task automatic testArm();
    int p0 = pulseCnt;
    doWrite(32'h8000_0005);
    doTicks(4);
    chk("R3 no early pulse", pulseCnt - p0, 0);
    chk("R2 readback running", regRdData, 32'h8000_0005);
    doTicks(1);
    chk("R3 pulse on 5th tick", {31'b0, timeoutPulse}, 1);
    chk("R6 read zero", regRdData, 32'h0);
    doIdle(1);
    chk("R6 single cycle", {31'b0, timeoutPulse}, 0);
    chk("R6 one pulse", pulseCnt - p0, 1);
  endtask

  task automatic testZero();
    doWrite(32'h8000_0000);
    doTicks(1);
    chk("R4 zero expires first tick", {31'b0, timeoutPulse}, 1);
    doIdle(1);
  endtask

  task automatic testCancel();
    int p0 = pulseCnt;
    doWrite(32'h8000_0003);
    doTicks(1);
    doWrite(32'h0000_0003);
    doTicks(10);
    chk("R5 no pulse after cancel", pulseCnt - p0, 0);
    chk("R5 read written word", regRdData, 32'h0000_0003);
  endtask

  task automatic testRestart();
    int p0 = pulseCnt;
    doWrite(32'h8000_000A);
    doTicks(3);
    doWrite(32'h8000_0002);
    doTicks(1);
    chk("R7 no pulse after 1 of 2", pulseCnt - p0, 0);
    doTicks(1);
    chk("R7 pulse after restart", {31'b0, timeoutPulse}, 1);
    doIdle(1);
  endtask

  task automatic testSparse();
    int p0 = pulseCnt;
    doWrite(32'h8000_0003);
    doTicks(1); doIdle(5);
    doTicks(1); doIdle(5);
    chk("R8 idle cycles not counted", pulseCnt - p0, 0);
    doTicks(1);
    chk("R8 pulse on 3rd tick", {31'b0, timeoutPulse}, 1);
    doIdle(1);
  endtask

  task automatic testNoSel();
    int p0 = pulseCnt;
    doWrite(32'h8000_0002);
    doWrite(32'h0000_0000, 1'b0);
    chk("R9 unselected write ignored", regRdData, 32'h8000_0002);
    doTicks(2);
    chk("R9 countdown unaffected", {31'b0, timeoutPulse}, 1);
    doIdle(1);
    chk("R9 one pulse", pulseCnt - p0, 1);
  endtask

  task automatic testWriteTick();
    int p0 = pulseCnt;
    doWrite(32'h8000_0002);
    doTicks(1);
    tickEn = 1'b1;
    doWrite(32'h8000_0003);
    tickEn = 1'b0;
    doTicks(2);
    chk("R10 same-cycle tick not counted", pulseCnt - p0, 0);
    doTicks(1);
    chk("R10 pulse after full new count", {31'b0, timeoutPulse}, 1);
    doIdle(1);
  endtask

  task automatic testHighBits();
    doWrite(32'hF800_0004);
    doTicks(2);
    chk("R2 high bits read back", regRdData, 32'hF800_0004);
    doTicks(2);
    chk("R3 high bits not in count", {31'b0, timeoutPulse}, 1);
    doIdle(1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0; regSel = 1'b0; regWr = 1'b0; regWrData = '0; tickEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testArm();
    testZero();
    testCancel();
    testRestart();
    testSparse();
    testNoSel();
    testWriteTick();
    testHighBits();
    finishRun();
  end

endmodule